// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a serial test port for a chip's pins. A tester drives a test clock, a mode-select line and a serial data input. A sixteen-state controller steps through the standard scan protocol. Each pass either moves a new 4-bit instruction into the device or moves data through the test register that the current instruction selects. The selectable registers are a 32-bit identification word, a one-bit pass-through stage and a chain of boundary cells. The boundary cells sit between the core logic and the pins.

The chain mixes four kinds of pin, and the count of each kind is a parameter. Input pins only capture. Plain output pins capture the core's value and can drive the pin. A tristate pin has a data cell and a separate enable cell. A bidirectional pin has a data cell, which captures the pad and drives it, and an enable cell. Every drive cell has an update latch behind its shift stage. Under the external-test instruction the pins follow those latches. Under any other instruction the pins follow the core. The pins appear as separate in, out and enable ports, so a pad ring outside the block builds the physical tristate buffers.

Top module: `scan_tap`

## Requirements
- R1: While trst_n is low, and after it rises, the controller is in Test-Logic-Reset, tdo_oe is 0, the active instruction is IDCODE and the pins follow the core.
- R2: Five consecutive rising TCK edges with TMS high bring the controller to Test-Logic-Reset from any state, and the IDCODE instruction becomes active again.
- R3: In Capture-IR the instruction shift stage loads 4'b0001. Shift-IR moves it out least significant bit first, so the first two bits out are 1 and then 0.
- R4: The active instruction changes only on the falling TCK edge while the controller is in Update-IR, or in Test-Logic-Reset. A rising edge never changes it.
- R5: The opcodes are 4'b0000 external test, 4'b0001 sample/preload, 4'b0010 IDCODE and 4'b1111 bypass. Every other opcode selects the bypass register.
- R6: The bypass register captures 0 in Capture-DR and delays TDI by one shift.
- R7: The identification register captures the IDCODE_VAL parameter, whose bit 0 is 1, and shifts it out least significant bit first.
- R8: TDO changes only on falling TCK edges, and tdo_oe is 1 only while the controller is in Shift-IR or Shift-DR.
- R9: In Capture-DR, when the chain is selected, the 12 chain bits read out first to last are: pad_in[1:0], cr_out_d[1:0], cr_tri_d[1:0], cr_tri_oe[1:0], pad_bidi_i[1:0], cr_bidi_oe[1:0]. Each field is read lowest index first. Output cells therefore capture the core-side value.
- R10: The update latches change only on the falling edge in Update-DR while the chain is selected. Driven pins hold their values while data shifts.
- R11: Under external test, pad_out, pad_tri_d, pad_tri_oe, pad_bidi_d and pad_bidi_oe come from the update latches of chain bits 2..11, in the R9 order. Under any other instruction they come from the matching core inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| tdo_oe | output | 1 | Output enable for tdo |
| pad_in | input | N_IN | Input pins |
| cr_in_q | output | N_IN | Input pin values passed to the core |
| cr_out_d | input | N_OUT | Core values for plain output pins |
| pad_out | output | N_OUT | Plain output pins |
| cr_tri_d | input | N_TRI | Core data for tristate pins |
| cr_tri_oe | input | N_TRI | Core enables for tristate pins |
| pad_tri_d | output | N_TRI | Tristate pin data |
| pad_tri_oe | output | N_TRI | Tristate pin enables |
| pad_bidi_i | input | N_BIDI | Values received on bidirectional pins |
| cr_bidi_q | output | N_BIDI | Received bidirectional values passed to the core |
| cr_bidi_d | input | N_BIDI | Core data for bidirectional pins |
| cr_bidi_oe | input | N_BIDI | Core enables for bidirectional pins |
| pad_bidi_d | output | N_BIDI | Bidirectional pin drive data |
| pad_bidi_oe | output | N_BIDI | Bidirectional pin drive enables |

## Verification
Two things can fall on the same falling edge: a new instruction is taken, and the pins switch source. When Update-IR replaces external test with sample/preload, the pins must switch from the latches to the core on that same edge. The bench first drives latch values that differ from the core. It then checks that the pins still show the latch values in Shift-IR and just after the rising edge into Update-IR, and that they show the core values just after the next falling edge. A TMS reset issued from inside Shift-DR while bypass is active is the second collision: the bench judges it by reading the identification word in the next scan.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;
  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0001;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'b0010;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPT   = 4'b0001;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e st_q
);
  tap_state_e st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_TLR:    st_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    st_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: st_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: st_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  st_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: st_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: st_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: st_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: st_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: st_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: st_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  st_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: st_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: st_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: st_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: st_d = tms ? ST_SEL_DR : ST_RTI;
      default:   st_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st_q <= ST_TLR;
    else         st_q <= st_d;
  end

  // run of consecutive high TMS samples, saturating at five
  logic [2:0] ones_q;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)             ones_q <= 3'd0;
    else if (!tms)           ones_q <= 3'd0;
    else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_q == 3'd5) |-> (st_q == ST_TLR)); // R2
endmodule

// File: rtl/ir_unit.sv
module ir_unit
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      st,
  output logic            ir_so,
  output logic [IR_W-1:0] ir_q
);
  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)               ir_sr <= IR_CAPT;
    else if (st == ST_CAP_IR)  ir_sr <= IR_CAPT;
    else if (st == ST_SH_IR)   ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  // active instruction moves on the falling edge only
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)               ir_q <= OP_IDCODE;
    else if (st == ST_TLR)     ir_q <= OP_IDCODE;
    else if (st == ST_UPD_IR)  ir_q <= ir_sr;
  end

  assign ir_so = ir_sr[0];

  AST_IR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    (st != ST_UPD_IR && st != ST_TLR) |-> $stable(ir_q)); // R4
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int N_IN   = 2,
  parameter int N_OUT  = 2,
  parameter int N_TRI  = 2,
  parameter int N_BIDI = 2
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  logic              cap_en,
  input  logic              sh_en,
  input  logic              upd_en,
  input  logic              extest,
  input  logic [N_IN-1:0]   pad_in,
  input  logic [N_OUT-1:0]  cr_out_d,
  input  logic [N_TRI-1:0]  cr_tri_d,
  input  logic [N_TRI-1:0]  cr_tri_oe,
  input  logic [N_BIDI-1:0] pad_bidi_i,
  input  logic [N_BIDI-1:0] cr_bidi_d,
  input  logic [N_BIDI-1:0] cr_bidi_oe,
  output logic [N_OUT-1:0]  pad_out,
  output logic [N_TRI-1:0]  pad_tri_d,
  output logic [N_TRI-1:0]  pad_tri_oe,
  output logic [N_BIDI-1:0] pad_bidi_d,
  output logic [N_BIDI-1:0] pad_bidi_oe,
  output logic              so
);
  localparam int B_OUT = N_IN;
  localparam int B_TD  = B_OUT + N_OUT;
  localparam int B_TC  = B_TD + N_TRI;
  localparam int B_BD  = B_TC + N_TRI;
  localparam int B_BC  = B_BD + N_BIDI;
  localparam int LEN   = B_BC + N_BIDI;

  logic [LEN-1:0]   cap_v;
  logic [LEN-1:0]   sr_q;
  logic [LEN-1:B_OUT] upd_q;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    assign cap_v[i] = pad_in[i];
  end
  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    assign cap_v[B_OUT+i] = cr_out_d[i];
    assign pad_out[i]     = extest ? upd_q[B_OUT+i] : cr_out_d[i];
  end
  for (genvar i = 0; i < N_TRI; i++) begin : g_tri
    assign cap_v[B_TD+i]  = cr_tri_d[i];
    assign cap_v[B_TC+i]  = cr_tri_oe[i];
    assign pad_tri_d[i]   = extest ? upd_q[B_TD+i] : cr_tri_d[i];
    assign pad_tri_oe[i]  = extest ? upd_q[B_TC+i] : cr_tri_oe[i];
  end
  for (genvar i = 0; i < N_BIDI; i++) begin : g_bidi
    assign cap_v[B_BD+i]  = pad_bidi_i[i];
    assign cap_v[B_BC+i]  = cr_bidi_oe[i];
    assign pad_bidi_d[i]  = extest ? upd_q[B_BD+i] : cr_bidi_d[i];
    assign pad_bidi_oe[i] = extest ? upd_q[B_BC+i] : cr_bidi_oe[i];
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     sr_q <= '0;
    else if (cap_en) sr_q <= cap_v;
    else if (sh_en)  sr_q <= {tdi, sr_q[LEN-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)     upd_q <= '0;
    else if (upd_en) upd_q <= sr_q[LEN-1:B_OUT];
  end

  assign so = sr_q[0];

  AST_UPD_ONLY_IN_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
    !upd_en |-> $stable(upd_q)); // R10
endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int          N_IN       = 2,
  parameter int          N_OUT      = 2,
  parameter int          N_TRI      = 2,
  parameter int          N_BIDI     = 2,
  parameter logic [31:0] IDCODE_VAL = 32'h4A37_C0D5
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_oe,
  input  logic [N_IN-1:0]   pad_in,
  output logic [N_IN-1:0]   cr_in_q,
  input  logic [N_OUT-1:0]  cr_out_d,
  output logic [N_OUT-1:0]  pad_out,
  input  logic [N_TRI-1:0]  cr_tri_d,
  input  logic [N_TRI-1:0]  cr_tri_oe,
  output logic [N_TRI-1:0]  pad_tri_d,
  output logic [N_TRI-1:0]  pad_tri_oe,
  input  logic [N_BIDI-1:0] pad_bidi_i,
  output logic [N_BIDI-1:0] cr_bidi_q,
  input  logic [N_BIDI-1:0] cr_bidi_d,
  input  logic [N_BIDI-1:0] cr_bidi_oe,
  output logic [N_BIDI-1:0] pad_bidi_d,
  output logic [N_BIDI-1:0] pad_bidi_oe
);
  tap_state_e      st;
  logic [IR_W-1:0] ir_q;
  logic            ir_so, bs_so;
  logic            sel_bs, sel_id, sel_byp, extest;
  logic [31:0]     id_sr;
  logic            byp_q;
  logic            dr_so, tdo_d, oe_d;

  tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .st_q(st));

  ir_unit u_ir (.tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st), .ir_so(ir_so), .ir_q(ir_q));

  assign extest  = (ir_q == OP_EXTEST);
  assign sel_bs  = extest || (ir_q == OP_SAMPLE);
  assign sel_id  = (ir_q == OP_IDCODE);
  assign sel_byp = !(sel_bs || sel_id);

  bscan_chain #(.N_IN(N_IN), .N_OUT(N_OUT), .N_TRI(N_TRI), .N_BIDI(N_BIDI)) u_chain (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .cap_en(sel_bs && st == ST_CAP_DR),
    .sh_en (sel_bs && st == ST_SH_DR),
    .upd_en(sel_bs && st == ST_UPD_DR),
    .extest(extest),
    .pad_in(pad_in), .cr_out_d(cr_out_d), .cr_tri_d(cr_tri_d), .cr_tri_oe(cr_tri_oe),
    .pad_bidi_i(pad_bidi_i), .cr_bidi_d(cr_bidi_d), .cr_bidi_oe(cr_bidi_oe),
    .pad_out(pad_out), .pad_tri_d(pad_tri_d), .pad_tri_oe(pad_tri_oe),
    .pad_bidi_d(pad_bidi_d), .pad_bidi_oe(pad_bidi_oe), .so(bs_so)
  );

  assign cr_in_q   = pad_in;
  assign cr_bidi_q = pad_bidi_i;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                       id_sr <= '0;
    else if (sel_id && st == ST_CAP_DR) id_sr <= IDCODE_VAL;
    else if (sel_id && st == ST_SH_DR)  id_sr <= {tdi, id_sr[31:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                        byp_q <= 1'b0;
    else if (sel_byp && st == ST_CAP_DR) byp_q <= 1'b0;
    else if (sel_byp && st == ST_SH_DR)  byp_q <= tdi;
  end

  always_comb begin
    if (sel_bs)      dr_so = bs_so;
    else if (sel_id) dr_so = id_sr[0];
    else             dr_so = byp_q;
    tdo_d = (st == ST_SH_IR) ? ir_so : dr_so;
    oe_d  = (st == ST_SH_IR) || (st == ST_SH_DR);
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_oe <= oe_d;
    end
  end

  AST_OE_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (st == ST_SH_IR || st == ST_SH_DR)); // R8
endmodule

// File: tb/scan_tap_bench.sv
`timescale 1ns/1ps
module scan_tap_bench;
  localparam logic [31:0] IDV = 32'h4A37_C0D5;

  logic tck = 1'b0;
  always #5 tck = ~tck;

  logic trst_n, tms, tdi;
  logic tdo, tdo_oe;
  logic [1:0] pad_in, cr_in_q, cr_out_d, pad_out, cr_tri_d, cr_tri_oe, pad_tri_d, pad_tri_oe;
  logic [1:0] pad_bidi_i, cr_bidi_q, cr_bidi_d, cr_bidi_oe, pad_bidi_d, pad_bidi_oe;

  scan_tap #(.IDCODE_VAL(IDV)) u_scan_tap (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pad_in(pad_in), .cr_in_q(cr_in_q), .cr_out_d(cr_out_d), .pad_out(pad_out),
    .cr_tri_d(cr_tri_d), .cr_tri_oe(cr_tri_oe), .pad_tri_d(pad_tri_d), .pad_tri_oe(pad_tri_oe),
    .pad_bidi_i(pad_bidi_i), .cr_bidi_q(cr_bidi_q), .cr_bidi_d(cr_bidi_d),
    .cr_bidi_oe(cr_bidi_oe), .pad_bidi_d(pad_bidi_d), .pad_bidi_oe(pad_bidi_oe)
  );

  int total = 0, bad = 0, ripple = 0, oe_err = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] pins();
    return {52'd0, pad_bidi_oe, pad_bidi_d, pad_tri_oe, pad_tri_d, pad_out, 2'b00};
  endfunction
  function automatic logic [63:0] core_side();
    return {52'd0, cr_bidi_oe, cr_bidi_d, cr_tri_oe, cr_tri_d, cr_out_d, 2'b00};
  endfunction
  function automatic logic [63:0] cap_exp();
    return {52'd0, cr_bidi_oe, pad_bidi_i, cr_tri_oe, cr_tri_d, cr_out_d, pad_in};
  endfunction
  task automatic set_core(input logic [11:0] v);
    pad_in = v[1:0]; cr_out_d = v[3:2]; cr_tri_d = v[5:4];
    cr_tri_oe = v[7:6]; pad_bidi_i = v[9:8]; cr_bidi_oe = v[11:10];
    cr_bidi_d = ~v[9:8];
  endtask

  // one TCK period; entered and left just after a falling edge
  task automatic step(input logic m, input logic d, output logic o);
    tms = m; tdi = d; o = tdo;
    @(posedge tck); #1;
    if (tdo !== o) ripple++;
    @(negedge tck); #1;
  endtask

  task automatic shift_ir(input logic [3:0] op, output logic [3:0] cap);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 4; i++) begin
      if (tdo_oe !== 1'b1) oe_err++;
      step(i == 3, op[i], o);
      cap[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din,
                          output logic [63:0] dout, output logic [63:0] pmid);
    logic o;
    dout = '0; pmid = '0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < n; i++) begin
      if (tdo_oe !== 1'b1) oe_err++;
      if (i == n / 2) pmid = pins();
      step(i == n - 1, din[i], o);
      dout[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [63:0] dout, pm, pv, q;
    logic [3:0]  cap;
    logic        o;
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    set_core(12'h000);
    repeat (3) @(negedge tck);
    #1 trst_n = 1'b1;
    check("R1 tdo_oe after reset", {63'd0, tdo_oe}, 64'd0);
    set_core(12'h9C6);
    #1 check("R1 R11 pins follow core after reset", pins(), core_side());
    step(0, 0, o);
    check("R1 idle tdo_oe", {63'd0, tdo_oe}, 64'd0);

    shift_dr(32, 64'd0, dout, pm);
    check("R1 R7 IDCODE active after reset", dout, {32'd0, IDV});
    check("R7 id bit0 is 1", {63'd0, dout[0]}, 64'd1);

    shift_ir(4'b1111, cap);
    check("R3 capture-IR pattern", {60'd0, cap}, 64'd1);

    // R5 R6: every opcode other than the three named ones behaves as bypass
    for (int op = 3; op < 16; op++) begin
      logic [63:0] d;
      d = 64'(8'hA5 ^ 8'(op * 29));
      shift_ir(4'(op), cap);
      shift_dr(8, d, dout, pm);
      check($sformatf("R5 R6 bypass opcode %0d", op), dout, {56'd0, d[6:0], 1'b0});
    end

    shift_ir(4'b0010, cap);
    shift_dr(32, 64'd0, dout, pm);
    check("R5 R7 IDCODE opcode", dout, {32'd0, IDV});

    // R9: sample/preload capture sweep
    shift_ir(4'b0001, cap);
    for (int k = 0; k < 8; k++) begin
      logic [11:0] v;
      v = 12'((k + 1) * 1187) ^ 12'(k << 7);
      set_core(v);
      pv = {52'd0, ~v};
      shift_dr(12, pv, dout, pm);
      check($sformatf("R9 sample capture k=%0d", k), dout, cap_exp());
      check($sformatf("R11 sample pins follow core k=%0d", k), pins(), core_side());
    end

    // R11: external test drives the preloaded latches
    shift_ir(4'b0000, cap);
    check("R11 extest pins from latches", pins(), {pv[63:2], 2'b00});
    set_core(12'h3A5);
    #1 check("R11 core change ignored in extest", pins(), {pv[63:2], 2'b00});
    q = {52'd0, 12'hB4E};
    shift_dr(12, q, dout, pm);
    check("R9 extest capture core side", dout, cap_exp());
    check("R10 pins hold during shift", pm, {pv[63:2], 2'b00});
    check("R10 pins after update", pins(), {q[63:2], 2'b00});

    // R4: instruction swap lands on the falling edge in Update-IR
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 4; i++) step(i == 3, (i == 0), o);
    check("R4 pins unchanged through Shift-IR", pins(), {q[63:2], 2'b00});
    tms = 1'b1;
    @(posedge tck); #1;
    check("R4 no change on rising edge into Update-IR", pins(), {q[63:2], 2'b00});
    @(negedge tck); #1;
    check("R4 R11 core drives after falling edge", pins(), core_side());
    step(0, 0, o);

    // R2: five TMS-high edges from inside Shift-DR under bypass
    shift_ir(4'b1111, cap);
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    step(0, 1, o);
    for (int i = 0; i < 5; i++) step(1, 0, o);
    check("R2 tdo_oe low in reset state", {63'd0, tdo_oe}, 64'd0);
    step(0, 0, o);
    shift_dr(32, 64'd0, dout, pm);
    check("R2 IDCODE after TMS reset", dout, {32'd0, IDV});

    // R1: asynchronous reset in the middle of operation
    shift_ir(4'b1111, cap);
    #2 trst_n = 1'b0;
    repeat (3) @(negedge tck);
    #1 trst_n = 1'b1;
    step(0, 0, o);
    shift_dr(32, 64'd0, dout, pm);
    check("R1 IDCODE after trst", dout, {32'd0, IDV});

    check("R8 tdo stable across rising edges", 64'(ripple), 64'd0);
    check("R8 tdo_oe high in every shift", 64'(oe_err), 64'd0);

    done = 1'b1;
    report();
  end
endmodule